// File: doc/BRIEF.md
# Video Test Pattern Generator with Bouncing Box

This block fills a video raster with synthetic picture content. An external timing source supplies the data-enable, horizontal sync and vertical sync pulses. The generator counts pixels and lines from those pulses and emits one RGB pixel per active cycle. It can draw one of four pictures: eight colour bars, a horizontal burst, a vertical burst, or a zone plate whose spatial frequency grows with position. An optional solid rectangle can be drawn over any of these pictures. Once per frame the rectangle moves by a programmable step on both axes and bounces off the frame edges.

Settings are written through a plain write port. Every write lands in a staging copy. The staging copy becomes live at the rising edge of vertical sync, so a picture never mixes old and new settings. The frame width is measured from the length of the last active line. The frame height is the number of lines counted since the previous vertical sync. The first frame after reset therefore sees a zero-sized frame. The outputs are a stream with a valid qualifier (`pix_valid`) but no ready. The timing source cannot be stalled, so the block accepts no back-pressure, and downstream logic must take one pixel on every cycle in which `pix_valid` is high. The syncs pass through with the same latency as the pixels.

Top module: `vid_pattern_gen`

## Requirements
- R1: `pix_valid`, `pix_hs` and `pix_vs` equal `tim_de`, `tim_hs` and `tim_vs` delayed by exactly OUT_STAGES clock cycles. `pix_data` is zero whenever `pix_valid` is low.
- R2: Mode 0 (colour bars) works as follows. Let S be the measured frame width divided by 8, latched at frame start. The pixel at column x shows bar min(x/S, 7), or bar 0 when S is 0. Bars 0 to 7 are white, yellow, cyan, green, magenta, red, blue and black. `pix_data` is {R[23:16], G[15:8], B[7:0]}, and each component is either all ones or zero.
- R3: Mode 1 (horizontal burst) gives all ones on every component when bit BURST_LOG of the column index is set, and zero otherwise.
- R4: Mode 2 (vertical burst) gives the same on/off picture, driven by bit BURST_LOG of the line index.
- R5: Mode 3 (zone plate) gives the grey value equal to bits [15:8] of (DH·x·(x−1)/2 + DV·y·(y−1)/2) mod 2^16 on all three components. DH is the horizontal delta and DV is the vertical delta.
- R6: When the box-enable bit is set, a pixel is replaced by the box colour if bx ≤ x < bx+W and by ≤ y < by+H. The box size is W by H.
- R7: At each frame start, the box position updates once per axis, using the incoming step and size. Moving forward: the box advances by the step if position+size+step ≤ frame extent; otherwise it reverses direction and holds its position. Moving backward: the box retreats by the step if position ≥ step; otherwise it reverses direction and holds its position. The position changes at no other time.
- R8: A register write takes effect on the picture only from the next rising edge of `tim_vs`.
- R9: After reset, every setting is zero (colour bars, box off, step 0, size 0, deltas 0). The box sits at the origin, heading right and down, and all outputs are low.
- R10: The register map is as follows. Address 0 holds the mode in [1:0] and box enable in [4]. Address 1 holds the step in [7:0]. Address 2 holds the box width in [11:0] and the box height in [27:16]. Address 3 holds the box colour in [23:0]. Addresses 4 and 5 hold DH and DV in [15:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| tim_de | input | 1 | Active-video qualifier from timing source |
| tim_hs | input | 1 | Horizontal sync from timing source |
| tim_vs | input | 1 | Vertical sync from timing source, rising edge starts a frame |
| pix_valid | output | 1 | Pixel valid, delayed data-enable |
| pix_data | output | 24 | RGB pixel, R in the top byte |
| pix_hs | output | 1 | Delayed horizontal sync |
| pix_vs | output | 1 | Delayed vertical sync |

## Verification
Each pattern is a closed-form function of the column and line, so a corrupt counter, accumulator or stripe divider shows as a wrong pixel within the same line, two cycles after the faulty input. A stale or early-loaded setting shows up on the very first active pixel of a frame. A box that moves wrongly shows as a misplaced coloured edge on the first line that crosses the box in the following frame. Delay skew between the sync path and the pixel path shows on the first blanking edge.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  localparam int CW    = 8;
  localparam int PXW   = 3 * CW;
  localparam int XW    = 12;
  localparam int YW    = 12;
  localparam int PHW   = 16;
  localparam int STEPW = 8;
  localparam int AW    = 3;
  localparam int DW    = 32;
  localparam int NBARS = 8;
  localparam int BAR_LOG = $clog2(NBARS);
  localparam int SIZE_H_LSB = 16;

  localparam logic [AW-1:0] A_CTRL = 3'd0;
  localparam logic [AW-1:0] A_STEP = 3'd1;
  localparam logic [AW-1:0] A_SIZE = 3'd2;
  localparam logic [AW-1:0] A_RGB  = 3'd3;
  localparam logic [AW-1:0] A_ZH   = 3'd4;
  localparam logic [AW-1:0] A_ZV   = 3'd5;
  localparam int CTRL_BOX_BIT = 4;

  typedef enum logic [1:0] {
    PAT_BARS   = 2'd0,
    PAT_HBURST = 2'd1,
    PAT_VBURST = 2'd2,
    PAT_ZONE   = 2'd3
  } pat_e;

  typedef struct packed {
    pat_e              pat;
    logic              box_en;
    logic [STEPW-1:0]  step;
    logic [XW-1:0]     box_w;
    logic [YW-1:0]     box_h;
    logic [PXW-1:0]    box_rgb;
    logic [PHW-1:0]    zdh;
    logic [PHW-1:0]    zdv;
  } cfg_t;

  typedef struct packed {
    logic           v;
    logic           hs;
    logic           vs;
    logic [PXW-1:0] d;
  } tap_t;

  // bar i: R off for i[1], G off for i[2], B off for i[0]
  function automatic logic [PXW-1:0] bar_rgb(input logic [BAR_LOG-1:0] i);
    return {{CW{~i[1]}}, {CW{~i[2]}}, {CW{~i[0]}}};
  endfunction
endpackage

// File: rtl/tpg_cfg.sv
module tpg_cfg
  import tpg_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          frame_start,
  output cfg_t          shadow,
  output cfg_t          active
);
  logic unused_wdata;
  assign unused_wdata = &{1'b0, wdata};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      if (frame_start) active <= shadow;
      if (we) begin
        case (addr)
          A_CTRL: begin
            shadow.pat    <= pat_e'(wdata[1:0]);
            shadow.box_en <= wdata[CTRL_BOX_BIT];
          end
          A_STEP: shadow.step    <= wdata[STEPW-1:0];
          A_SIZE: begin
            shadow.box_w <= wdata[XW-1:0];
            shadow.box_h <= wdata[SIZE_H_LSB +: YW];
          end
          A_RGB:  shadow.box_rgb <= wdata[PXW-1:0];
          A_ZH:   shadow.zdh     <= wdata[PHW-1:0];
          A_ZV:   shadow.zdv     <= wdata[PHW-1:0];
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/tpg_scan.sv
module tpg_scan
  import tpg_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               de,
  input  logic               vs,
  output logic               frame_start,
  output logic               line_end,
  output logic [XW-1:0]      x,
  output logic [YW-1:0]      y,
  output logic [XW-1:0]      frame_w,
  output logic [BAR_LOG-1:0] bar_idx
);
  localparam logic [XW-1:0] X_ONE = 1;
  localparam logic [BAR_LOG-1:0] LAST_BAR = BAR_LOG'(NBARS - 1);

  logic          de_d, vs_d;
  logic [XW-1:0] stripe_w, stripe_cnt;

  assign frame_start = vs & ~vs_d;
  assign line_end    = de_d & ~de;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_d <= 1'b0;
      vs_d <= 1'b0;
      x <= '0;
      y <= '0;
      frame_w <= '0;
      stripe_w <= '0;
    end else begin
      de_d <= de;
      vs_d <= vs;
      x <= de ? x + X_ONE : '0;
      if (line_end) frame_w <= x;
      if (frame_start) begin
        y <= '0;
        stripe_w <= frame_w >> BAR_LOG;
      end else if (line_end) begin
        y <= y + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !de) begin
      stripe_cnt <= '0;
      bar_idx <= '0;
    end else if (stripe_cnt == stripe_w - X_ONE && bar_idx != LAST_BAR) begin
      stripe_cnt <= '0;
      bar_idx <= bar_idx + 1'b1;
    end else begin
      stripe_cnt <= stripe_cnt + X_ONE;
    end
  end
endmodule

// File: rtl/tpg_zone.sv
module tpg_zone
  import tpg_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           de,
  input  logic           line_end,
  input  logic           frame_start,
  input  logic [PHW-1:0] dh,
  input  logic [PHW-1:0] dv,
  output logic [CW-1:0]  grey
);
  logic [PHW-1:0] h_ph, h_inc, v_ph, v_inc, sum;

  always_ff @(posedge clk) begin
    if (!rst_n || !de) begin
      h_ph  <= '0;
      h_inc <= '0;
    end else begin
      h_ph  <= h_ph + h_inc;
      h_inc <= h_inc + dh;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || frame_start) begin
      v_ph  <= '0;
      v_inc <= '0;
    end else if (line_end) begin
      v_ph  <= v_ph + v_inc;
      v_inc <= v_inc + dv;
    end
  end

  assign sum  = h_ph + v_ph;
  assign grey = sum[PHW-1 -: CW];
endmodule

// File: rtl/tpg_box.sv
module tpg_box
  import tpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_start,
  input  logic [STEPW-1:0] nxt_step,
  input  logic [XW-1:0]    nxt_w,
  input  logic [YW-1:0]    nxt_h,
  input  logic [XW-1:0]    cur_w,
  input  logic [YW-1:0]    cur_h,
  input  logic [XW-1:0]    frame_w,
  input  logic [XW-1:0]    x,
  input  logic [YW-1:0]    y,
  output logic [XW-1:0]    box_x,
  output logic [YW-1:0]    box_y,
  output logic             hit
);
  localparam int XE = XW + 1;
  localparam int YE = YW + 1;

  logic fwd_x, fwd_y;
  logic fits_x, fits_y, room_x, room_y;

  // at frame_start, y still holds the line count of the frame just ended
  assign fits_x = (XE'(box_x) + XE'(nxt_w) + XE'(nxt_step)) <= XE'(frame_w);
  assign fits_y = (YE'(box_y) + YE'(nxt_h) + YE'(nxt_step)) <= YE'(y);
  assign room_x = box_x >= XW'(nxt_step);
  assign room_y = box_y >= YW'(nxt_step);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      box_x <= '0;
      box_y <= '0;
      fwd_x <= 1'b1;
      fwd_y <= 1'b1;
    end else if (frame_start) begin
      if (fwd_x) begin
        if (fits_x) box_x <= box_x + XW'(nxt_step);
        else        fwd_x <= 1'b0;
      end else begin
        if (room_x) box_x <= box_x - XW'(nxt_step);
        else        fwd_x <= 1'b1;
      end
      if (fwd_y) begin
        if (fits_y) box_y <= box_y + YW'(nxt_step);
        else        fwd_y <= 1'b0;
      end else begin
        if (room_y) box_y <= box_y - YW'(nxt_step);
        else        fwd_y <= 1'b1;
      end
    end
  end

  assign hit = (x >= box_x) && (XE'(x) < XE'(box_x) + XE'(cur_w)) &&
               (y >= box_y) && (YE'(y) < YE'(box_y) + YE'(cur_h));
endmodule

// File: rtl/vid_pattern_gen.sv
module vid_pattern_gen
  import tpg_pkg::*;
#(
  parameter int OUT_STAGES = 2,
  parameter int BURST_LOG  = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_we,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  input  logic           tim_de,
  input  logic           tim_hs,
  input  logic           tim_vs,
  output logic           pix_valid,
  output logic [PXW-1:0] pix_data,
  output logic           pix_hs,
  output logic           pix_vs
);
  cfg_t               shd_cfg, act_cfg;
  logic               frame_start, line_end, hit;
  logic [XW-1:0]      x, frame_w, box_x;
  logic [YW-1:0]      y, box_y;
  logic [BAR_LOG-1:0] bar_idx;
  logic [CW-1:0]      grey;
  logic [PXW-1:0]     base_px, px;
  tap_t               head;
  tap_t               pipe [1:OUT_STAGES];

  tpg_cfg u_cfg (
    .clk, .rst_n, .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .frame_start, .shadow(shd_cfg), .active(act_cfg)
  );

  tpg_scan u_scan (
    .clk, .rst_n, .de(tim_de), .vs(tim_vs), .frame_start, .line_end,
    .x, .y, .frame_w, .bar_idx
  );

  tpg_zone u_zone (
    .clk, .rst_n, .de(tim_de), .line_end, .frame_start,
    .dh(act_cfg.zdh), .dv(act_cfg.zdv), .grey
  );

  tpg_box u_box (
    .clk, .rst_n, .frame_start,
    .nxt_step(shd_cfg.step), .nxt_w(shd_cfg.box_w), .nxt_h(shd_cfg.box_h),
    .cur_w(act_cfg.box_w), .cur_h(act_cfg.box_h), .frame_w,
    .x, .y, .box_x, .box_y, .hit
  );

  always_comb begin
    case (act_cfg.pat)
      PAT_BARS:   base_px = bar_rgb(bar_idx);
      PAT_HBURST: base_px = {PXW{x[BURST_LOG]}};
      PAT_VBURST: base_px = {PXW{y[BURST_LOG]}};
      default:    base_px = {3{grey}};
    endcase
    px = (act_cfg.box_en && hit) ? act_cfg.box_rgb : base_px;
  end

  assign head = '{v: tim_de, hs: tim_hs, vs: tim_vs, d: tim_de ? px : '0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= OUT_STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[1] <= head;
      for (int i = 2; i <= OUT_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign pix_valid = pipe[OUT_STAGES].v;
  assign pix_hs    = pipe[OUT_STAGES].hs;
  assign pix_vs    = pipe[OUT_STAGES].vs;
  assign pix_data  = pipe[OUT_STAGES].d;
endmodule

// File: rtl/vid_pattern_gen_chk.sv
module vid_pattern_gen_chk
  import tpg_pkg::*;
#(
  parameter int OUT_STAGES = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tim_de,
  input logic           tim_hs,
  input logic           tim_vs,
  input logic           pix_valid,
  input logic           pix_hs,
  input logic           pix_vs,
  input logic [PXW-1:0] pix_data,
  input logic           frame_start,
  input cfg_t           act_cfg,
  input logic [XW-1:0]  box_x,
  input logic [YW-1:0]  box_y
);
  logic [2:0] ref_q [1:OUT_STAGES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 1; i <= OUT_STAGES; i++) ref_q[i] <= '0;
    end else begin
      ref_q[1] <= {tim_de, tim_hs, tim_vs};
      for (int i = 2; i <= OUT_STAGES; i++) ref_q[i] <= ref_q[i-1];
    end
  end

  assert_sync_delay_R1: assert property (@(posedge clk) disable iff (!rst_n)
    {pix_valid, pix_hs, pix_vs} == ref_q[OUT_STAGES]);

  assert_blank_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |-> pix_data == '0);

  assert_cfg_frame_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(act_cfg));

  assert_box_frame_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(box_x) && $stable(box_y)));
endmodule

bind vid_pattern_gen vid_pattern_gen_chk #(.OUT_STAGES(OUT_STAGES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tim_de(tim_de), .tim_hs(tim_hs), .tim_vs(tim_vs),
  .pix_valid(pix_valid), .pix_hs(pix_hs), .pix_vs(pix_vs), .pix_data(pix_data),
  .frame_start(frame_start), .act_cfg(act_cfg), .box_x(box_x), .box_y(box_y)
);

// File: tb/sim_vid_pattern_gen.sv
module sim_vid_pattern_gen;
  import tpg_pkg::*;
  localparam int LAT = 2;
  localparam int BL  = 2;
  localparam int FW  = 32;
  localparam int FH  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, de = 1'b0, hs = 1'b0, vs = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wd = '0;
  logic pix_valid, pix_hs, pix_vs;
  logic [PXW-1:0] pix_data;

  vid_pattern_gen #(.OUT_STAGES(LAT), .BURST_LOG(BL)) u0 (
    .clk, .rst_n, .reg_we(we), .reg_addr(addr), .reg_wdata(wd),
    .tim_de(de), .tim_hs(hs), .tim_vs(vs),
    .pix_valid, .pix_data, .pix_hs, .pix_vs
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  string cur_req = "R9";

  // model state: staging and live settings, box, bar width
  int s_pat = 0, s_en = 0, s_step = 0, s_bw = 0, s_bh = 0, s_dh = 0, s_dv = 0;
  int a_pat = 0, a_en = 0, a_bw = 0, a_bh = 0, a_dh = 0, a_dv = 0;
  logic [23:0] s_rgb = '0, a_rgb = '0;
  int bx = 0, by = 0, sw = 0, fcount = 0;
  bit dx = 1, dy = 1, vs_prev = 0;
  logic [26:0] e1 = '0, e2 = '0;
  bit pend = 0;
  int pend_a = 0;
  logic [31:0] pend_d = '0;

  task automatic check(string req, logic [26:0] got, logic [26:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply_wr(int a, logic [31:0] d);
    case (a)
      0: begin s_pat = int'(d[1:0]); s_en = int'(d[4]); end
      1: s_step = int'(d[7:0]);
      2: begin s_bw = int'(d[11:0]); s_bh = int'(d[27:16]); end
      3: s_rgb = d[23:0];
      4: s_dh = int'(d[15:0]);
      5: s_dv = int'(d[15:0]);
      default: ;
    endcase
  endtask

  task automatic model_frame_start();
    int w, h;
    w = (fcount == 0) ? 0 : FW;
    h = (fcount == 0) ? 0 : FH;
    fcount++;
    a_pat = s_pat; a_en = s_en; a_bw = s_bw; a_bh = s_bh;
    a_rgb = s_rgb; a_dh = s_dh; a_dv = s_dv;
    sw = w / 8;
    // R7 bounce rule
    if (dx) begin if (bx + s_bw + s_step <= w) bx += s_step; else dx = 0; end
    else begin if (bx >= s_step) bx -= s_step; else dx = 1; end
    if (dy) begin if (by + s_bh + s_step <= h) by += s_step; else dy = 0; end
    else begin if (by >= s_step) by -= s_step; else dy = 1; end
  endtask

  function automatic logic [23:0] model_pix(int x, int y);
    logic [23:0] p;
    logic [2:0] bi;
    longint hsum;
    logic [7:0] z;
    int idx;
    case (a_pat)
      0: begin
        idx = (sw == 0) ? 0 : x / sw;
        if (idx > 7) idx = 7;
        bi = idx[2:0];
        p = {{8{~bi[1]}}, {8{~bi[2]}}, {8{~bi[0]}}};
      end
      1: p = ((x >> BL) & 1) != 0 ? 24'hffffff : 24'h0;
      2: p = ((y >> BL) & 1) != 0 ? 24'hffffff : 24'h0;
      default: begin
        hsum = longint'(a_dh) * x * (x - 1) / 2 + longint'(a_dv) * y * (y - 1) / 2;
        z = hsum[15:8];
        p = {z, z, z};
      end
    endcase
    if (a_en != 0 && x >= bx && x < bx + a_bw && y >= by && y < by + a_bh) p = a_rgb;
    return p;
  endfunction

  task automatic cyc(bit d, bit h, bit v, int x, int y);
    logic [26:0] got;
    @(negedge clk);
    got = {pix_valid, pix_hs, pix_vs, pix_data};
    check((got[26:24] !== e2[26:24]) ? "R1" : cur_req, got, e2);
    e2 = e1;
    if (v && !vs_prev) model_frame_start();
    vs_prev = v;
    e1 = {d, h, v, d ? model_pix(x, y) : 24'h0};
    de = d; hs = h; vs = v;
    if (pend) begin
      we = 1'b1; addr = AW'(pend_a); wd = pend_d;
      apply_wr(pend_a, pend_d);
      pend = 0;
    end else begin
      we = 1'b0;
    end
  endtask

  task automatic reg_write(int a, logic [31:0] d);
    pend = 1; pend_a = a; pend_d = d;
    cyc(0, 0, 0, 0, 0);
  endtask

  task automatic run_frame(bit mid, int ma, logic [31:0] md);
    for (int i = 0; i < 4; i++) cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 2; i++) cyc(0, 0, 0, 0, 0);
    for (int yy = 0; yy < FH; yy++) begin
      for (int i = 0; i < 2; i++) cyc(0, 1, 0, 0, 0);
      for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);
      for (int xx = 0; xx < FW; xx++) begin
        if (mid && yy == 3 && xx == 10) begin pend = 1; pend_a = ma; pend_d = md; end
        cyc(1, 0, 0, xx, yy);
      end
    end
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R9: outputs low in reset
    check("R9", {pix_valid, pix_hs, pix_vs, pix_data}, 27'h0);
    rst_n = 1'b1;
    // R9 and R2: reset defaults give colour bars; frame 0 has zero width
    cur_req = "R9";
    run_frame(0, 0, 0);
    run_frame(0, 0, 0);
    cur_req = "R2";
    run_frame(0, 0, 0);
    // R3 horizontal burst, R10 control field
    cur_req = "R3";
    reg_write(0, 32'h1);
    run_frame(0, 0, 0);
    run_frame(0, 0, 0);
    // R4 vertical burst
    cur_req = "R4";
    reg_write(0, 32'h2);
    run_frame(0, 0, 0);
    run_frame(0, 0, 0);
    // R5 zone plate, two delta settings
    cur_req = "R5";
    reg_write(4, 32'h0123);
    reg_write(5, 32'h0456);
    reg_write(0, 32'h3);
    run_frame(0, 0, 0);
    run_frame(0, 0, 0);
    reg_write(4, 32'h7fff);
    reg_write(5, 32'h00f1);
    run_frame(0, 0, 0);
    // R6 stationary box over bars
    cur_req = "R6";
    reg_write(2, (32'd3 << 16) | 32'd6);
    reg_write(3, 32'h123456);
    reg_write(0, 32'h10);
    run_frame(0, 0, 0);
    run_frame(0, 0, 0);
    // R7 moving, bouncing box over zone plate
    cur_req = "R7";
    reg_write(1, 32'd5);
    reg_write(0, 32'h13);
    for (int f = 0; f < 12; f++) run_frame(0, 0, 0);
    // R8 mid-frame write waits for the next frame start
    cur_req = "R8";
    reg_write(1, 32'd0);
    reg_write(0, 32'h0);
    run_frame(0, 0, 0);
    run_frame(1, 0, 32'h2);
    run_frame(0, 0, 0);
    for (int i = 0; i < LAT + 2; i++) cyc(0, 0, 0, 0, 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1: watchdog expired, actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule